// File: doc/BRIEF.md
# LCD Scanline Timing Generator

This block generates the horizontal and vertical timing of a small LCD panel, counted directly in system clock cycles. Each scanline begins with an active drawing interval, followed by a horizontal blanking interval. A line counter steps through the visible lines and then the vertical blanking lines, and wraps at the end of the frame.

Alongside the counter, the block keeps a 16-bit display status word. Its low bits are flags that the timing drives. The host programs three interrupt enables and an 8-bit line-compare value through a simple write port. From the same state the block emits several one-cycle pulses:
- interrupt requests for hblank, vblank and line match;
- DMA trigger strobes at hblank and at the start of vblank;
- a frame-complete strobe.

Rendering, the DMA engine and interrupt arbitration sit outside the block. By default a line is 960 + 272 cycles and a frame is 228 lines, of which the first 160 are visible.

Top module: `lcd_scan_timing`

## Requirements
- R1: While reset is held and in the first cycle after it, lineCount is 0, status reads 0x0000 and every pulse output is low.
- R2: A line lasts ACTIVE_CYC + HBLANK_CYC cycles. Status bit 1 (hblank) becomes 1 once ACTIVE_CYC cycles of the line have elapsed, and returns to 0 when the next line starts.
- R3: lineCount advances by one at each line start, counts 0 to TOTAL_LINES-1, and then wraps to 0.
- R4: Status bit 0 (vblank) becomes 1 when line VIS_LINES starts and becomes 0 when the counter wraps to 0.
- R5: Status bit 2 (line match) is evaluated at every line start as (new line number == status bits 15:8) and holds that value for the whole line. After reset it stays 0 until the first line start.
- R6: A write with wrEn updates only status bits 3, 4, 5 and 15:8 from the same bits of wrData. Bits 0 to 2 are not writable, and bits 7:6 always read 0.
- R7: irqHblank pulses on every hblank entry, visible or not, when bit 4 is set.
- R8: irqVblank pulses on entry to line VIS_LINES when bit 3 is set.
- R9: irqMatch pulses at a line start whose evaluation sets the match flag, when bit 5 is set.
- R10: dmaHblank pulses on hblank entry only while the vblank flag is 0, whatever the enables.
- R11: dmaVblank pulses on entry to line VIS_LINES, whatever the enables.
- R12: frameDone pulses once per frame, in the cycle where lineCount first reads 0 after the wrap.
- R13: Every pulse output is high for exactly one cycle, the same cycle in which its flag transition first becomes visible on status or lineCount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Host write strobe for the status word |
| wrData | input | 16 | Host write data; only bits 3-5 and 15:8 are used |
| status | output | 16 | Display status word |
| lineCount | output | $clog2(TOTAL_LINES) | Current line number |
| irqHblank | output | 1 | Hblank interrupt request pulse |
| irqVblank | output | 1 | Vblank interrupt request pulse |
| irqMatch | output | 1 | Line-match interrupt request pulse |
| dmaHblank | output | 1 | Hblank DMA trigger pulse, visible lines only |
| dmaVblank | output | 1 | Vblank DMA trigger pulse |
| frameDone | output | 1 | Frame-complete pulse |

## Verification
Errors in the horizontal cycle counter move the hblank flag and its pulses by whole cycles on the very first line, so a cycle-by-cycle comparison catches them within one line. Errors in the line counter or in the vblank sequencing show up on lineCount, on status bit 0 and on the vblank strobes, at the latest when line VIS_LINES starts or when the frame wraps. An error in the compare path or in the write masking appears on status bits 2 to 7 in the first cycle after the write or the next line start. The bench therefore follows every cycle of more than two frames per scenario, using reduced line and frame sizes.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  // Strobes passed from the horizontal sequencer to the status datapath
  typedef struct packed {
    logic hbEnter;  // next edge begins horizontal blank
    logic lineEnd;  // next edge begins a new line
  } lcdtStrobe_t;

  localparam int STAT_W = 16;
  localparam int CMP_LO = 8;
endpackage

// File: rtl/lcdt_seq.sv
module lcdt_seq
  import lcdt_pkg::*;
#(
  parameter int ACTIVE_CYC = 960,
  parameter int HBLANK_CYC = 272
) (
  input  logic        clk,
  input  logic        rst,
  output lcdtStrobe_t stb
);
  localparam int LINE_CYC = ACTIVE_CYC + HBLANK_CYC;
  localparam int CYC_W    = $clog2(LINE_CYC);
  localparam logic [CYC_W-1:0] HB_AT  = CYC_W'(ACTIVE_CYC - 1);
  localparam logic [CYC_W-1:0] END_AT = CYC_W'(LINE_CYC - 1);

  logic [CYC_W-1:0] cycQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycQ <= '0;
    end else if (cycQ == END_AT) begin
      cycQ <= '0;
    end else begin
      cycQ <= cycQ + 1'b1;
    end
  end

  always_comb begin
    stb.hbEnter = (cycQ == HB_AT);
    stb.lineEnd = (cycQ == END_AT);
  end
endmodule

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
#(
  parameter int VIS_LINES   = 160,
  parameter int TOTAL_LINES = 228
) (
  input  logic                           clk,
  input  logic                           rst,
  input  lcdtStrobe_t                    stb,
  input  logic                           wrEn,
  input  logic [STAT_W-1:0]              wrData,
  output logic [STAT_W-1:0]              status,
  output logic [$clog2(TOTAL_LINES)-1:0] lineCount,
  output logic                           irqHblank,
  output logic                           irqVblank,
  output logic                           irqMatch,
  output logic                           dmaHblank,
  output logic                           dmaVblank,
  output logic                           frameDone
);
  localparam int LINE_W = $clog2(TOTAL_LINES);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);
  localparam logic [LINE_W-1:0] VB_LINE   = LINE_W'(VIS_LINES);

  logic [LINE_W-1:0] lineQ, nextLine;
  logic              vbFlag, hbFlag, matchFlag;
  logic              enVb, enHb, enMatch;
  logic [7:0]        cmpQ;
  logic              wrapNow, vbEnterNow, matchNow;
  logic              unusedBits;

  assign unusedBits = ^{wrData[7:6], wrData[2:0]};

  always_comb begin
    nextLine   = (lineQ == LAST_LINE) ? '0 : lineQ + 1'b1;
    wrapNow    = stb.lineEnd && (lineQ == LAST_LINE);
    vbEnterNow = stb.lineEnd && (nextLine == VB_LINE);
    matchNow   = (16'(nextLine) == {8'd0, cmpQ});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineQ     <= '0;
      vbFlag    <= 1'b0;
      hbFlag    <= 1'b0;
      matchFlag <= 1'b0;
      enVb      <= 1'b0;
      enHb      <= 1'b0;
      enMatch   <= 1'b0;
      cmpQ      <= '0;
      irqHblank <= 1'b0;
      irqVblank <= 1'b0;
      irqMatch  <= 1'b0;
      dmaHblank <= 1'b0;
      dmaVblank <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      irqHblank <= 1'b0;
      irqVblank <= 1'b0;
      irqMatch  <= 1'b0;
      dmaHblank <= 1'b0;
      dmaVblank <= 1'b0;
      frameDone <= 1'b0;
      if (wrEn) begin
        enVb    <= wrData[3];
        enHb    <= wrData[4];
        enMatch <= wrData[5];
        cmpQ    <= wrData[15:CMP_LO];
      end
      if (stb.hbEnter) begin
        hbFlag    <= 1'b1;
        irqHblank <= enHb;
        dmaHblank <= !vbFlag;
      end
      if (stb.lineEnd) begin
        hbFlag    <= 1'b0;
        lineQ     <= nextLine;
        matchFlag <= matchNow;
        irqMatch  <= enMatch && matchNow;
        if (vbEnterNow) begin
          vbFlag    <= 1'b1;
          irqVblank <= enVb;
          dmaVblank <= 1'b1;
        end
        if (wrapNow) begin
          vbFlag    <= 1'b0;
          frameDone <= 1'b1;
        end
      end
    end
  end

  assign status    = {cmpQ, 2'b00, enMatch, enHb, enVb, matchFlag, hbFlag, vbFlag};
  assign lineCount = lineQ;
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcdt_pkg::*;
#(
  parameter int ACTIVE_CYC  = 960,
  parameter int HBLANK_CYC  = 272,
  parameter int VIS_LINES   = 160,
  parameter int TOTAL_LINES = 228
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wrEn,
  input  logic [15:0]                    wrData,
  output logic [15:0]                    status,
  output logic [$clog2(TOTAL_LINES)-1:0] lineCount,
  output logic                           irqHblank,
  output logic                           irqVblank,
  output logic                           irqMatch,
  output logic                           dmaHblank,
  output logic                           dmaVblank,
  output logic                           frameDone
);
  lcdtStrobe_t stb;

  lcdt_seq #(
    .ACTIVE_CYC(ACTIVE_CYC),
    .HBLANK_CYC(HBLANK_CYC)
  ) u_seq (
    .clk(clk),
    .rst(rst),
    .stb(stb)
  );

  lcdt_regs #(
    .VIS_LINES(VIS_LINES),
    .TOTAL_LINES(TOTAL_LINES)
  ) u_regs (
    .clk(clk),
    .rst(rst),
    .stb(stb),
    .wrEn(wrEn),
    .wrData(wrData),
    .status(status),
    .lineCount(lineCount),
    .irqHblank(irqHblank),
    .irqVblank(irqVblank),
    .irqMatch(irqMatch),
    .dmaHblank(dmaHblank),
    .dmaVblank(dmaVblank),
    .frameDone(frameDone)
  );
endmodule

// File: rtl/lcd_scan_timing_chk.sv
module lcd_scan_timing_chk #(
  parameter int VIS_LINES   = 160,
  parameter int TOTAL_LINES = 228
) (
  input logic                           clk,
  input logic                           rst,
  input logic [15:0]                    status,
  input logic [$clog2(TOTAL_LINES)-1:0] lineCount,
  input logic                           irqHblank,
  input logic                           irqVblank,
  input logic                           irqMatch,
  input logic                           dmaHblank,
  input logic                           dmaVblank,
  input logic                           frameDone
);
  localparam int LINE_W = $clog2(TOTAL_LINES);

  p_line_step_r3: assert property (@(posedge clk) disable iff (rst)
    (lineCount != $past(lineCount)) |->
      (lineCount == '0 || lineCount == $past(lineCount) + 1'b1));

  p_hb_irq_r7: assert property (@(posedge clk) disable iff (rst)
    irqHblank |-> (status[4] && status[1] && !$past(status[1])));

  p_vb_irq_r8: assert property (@(posedge clk) disable iff (rst)
    irqVblank |-> (status[3] && status[0] && !$past(status[0])));

  p_match_irq_r9: assert property (@(posedge clk) disable iff (rst)
    irqMatch |-> (status[5] && status[2]));

  p_hdma_visible_r10: assert property (@(posedge clk) disable iff (rst)
    dmaHblank |-> (!status[0] && status[1]));

  p_vdma_line_r11: assert property (@(posedge clk) disable iff (rst)
    dmaVblank |-> (lineCount == LINE_W'(VIS_LINES) && status[0]));

  p_frame_wrap_r12: assert property (@(posedge clk) disable iff (rst)
    frameDone |-> (lineCount == '0 && !status[0]));

  p_spare_zero_r6: assert property (@(posedge clk) disable iff (rst)
    status[7:6] == 2'b00);

  p_single_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    (irqVblank || dmaVblank || frameDone) |=> !(irqVblank || dmaVblank || frameDone));
endmodule

bind lcd_scan_timing lcd_scan_timing_chk #(
  .VIS_LINES(VIS_LINES),
  .TOTAL_LINES(TOTAL_LINES)
) u_chk (
  .clk(clk),
  .rst(rst),
  .status(status),
  .lineCount(lineCount),
  .irqHblank(irqHblank),
  .irqVblank(irqVblank),
  .irqMatch(irqMatch),
  .dmaHblank(dmaHblank),
  .dmaVblank(dmaVblank),
  .frameDone(frameDone)
);

// File: tb/lcd_scan_timing_bench.sv
module lcd_scan_timing_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ACT = 6;
  localparam int HBL = 3;
  localparam int VIS = 4;
  localparam int TOT = 7;
  localparam int LINE = ACT + HBL;
  localparam int LW = $clog2(TOT);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] status;
  logic [LW-1:0] lineCount;
  logic irqHblank, irqVblank, irqMatch, dmaHblank, dmaVblank, frameDone;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan_timing #(
    .ACTIVE_CYC(ACT), .HBLANK_CYC(HBL), .VIS_LINES(VIS), .TOTAL_LINES(TOT)
  ) u_lcd_scan_timing (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .status(status), .lineCount(lineCount),
    .irqHblank(irqHblank), .irqVblank(irqVblank), .irqMatch(irqMatch),
    .dmaHblank(dmaHblank), .dmaVblank(dmaVblank), .frameDone(frameDone)
  );

  task automatic chk(input string req, input string what, input int act, input int exp, input int p);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, p, act, exp);
    end
  endtask

  // Compare all outputs with values derived from elapsed cycles p since reset release
  task automatic checkCycle(input int p, input logic [15:0] cfg);
    int hpos = p % LINE;
    int ln = (p / LINE) % TOT;
    bit cfgOn = (p >= 1);
    int cmp = cfgOn ? int'(cfg[15:8]) : 0;
    bit eV = cfgOn && cfg[3];
    bit eH = cfgOn && cfg[4];
    bit eM = cfgOn && cfg[5];
    bit hb = (hpos >= ACT);
    bit vb = (ln >= VIS);
    bit mf = (p >= LINE) && (ln == cmp);
    bit lineStart = (p > 0) && (hpos == 0);
    logic [15:0] expStat = {8'(cmp), 2'b00, eM, eH, eV, mf, hb, vb};
    chk("R3", "lineCount", int'(lineCount), ln, p);
    chk("R2", "hblank flag", int'(status[1]), int'(hb), p);
    chk("R4", "vblank flag", int'(status[0]), int'(vb), p);
    chk("R5", "match flag", int'(status[2]), int'(mf), p);
    chk("R6", "status word", int'(status), int'(expStat), p);
    chk("R7", "irqHblank", int'(irqHblank), int'(hpos == ACT && eH), p);
    chk("R8", "irqVblank", int'(irqVblank), int'(lineStart && ln == VIS && eV), p);
    chk("R9", "irqMatch", int'(irqMatch), int'(lineStart && ln == cmp && eM), p);
    chk("R10", "dmaHblank", int'(dmaHblank), int'(hpos == ACT && ln < VIS), p);
    chk("R11", "dmaVblank", int'(dmaVblank), int'(lineStart && ln == VIS), p);
    chk("R12", "frameDone", int'(frameDone), int'(lineStart && ln == 0), p);
  endtask

  // Reset, write cfg in the first cycle, then follow more than two frames (R13 alignment)
  task automatic runScenario(input logic [15:0] cfg);
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wrEn = 1'b1;
    wrData = cfg;
    checkCycle(0, cfg);
    for (int p = 1; p <= 2 * LINE * TOT + 10; p++) begin
      @(negedge clk);
      wrEn = 1'b0;
      wrData = 16'h0000;
      checkCycle(p, cfg);
    end
  endtask

  task automatic testReset();
    @(negedge clk) rst = 1'b1;
    wrEn = 1'b1;
    wrData = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R1: writes under reset are discarded and everything reads idle
    chk("R1", "status in reset", int'(status), 0, 0);
    chk("R1", "lineCount in reset", int'(lineCount), 0, 0);
    chk("R1", "pulses in reset",
        int'({irqHblank, irqVblank, irqMatch, dmaHblank, dmaVblank, frameDone}), 0, 0);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic testAllEnabled();   // R7 R8 R9, compare on line 3
    runScenario(16'h0338);
  endtask

  task automatic testNoEnables();    // R10 R11 still pulse, no interrupts
    runScenario(16'h0200);
  endtask

  task automatic testWriteMask();    // R6: bits 0-2 and 7:6 unaffected, cmp never hit
    runScenario(16'hFFC7);
  endtask

  task automatic testCompareZero();  // R5 R9: match on wrap to line 0
    runScenario(16'h0020);
  endtask

  task automatic testCompareVblank(); // R5 R9 in vblank on the last line
    runScenario(16'h0638);
  endtask

  initial begin
    testReset();
    testAllEnabled();
    testNoEnables();
    testWriteMask();
    testCompareZero();
    testCompareVblank();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule